// File: doc/BRIEF.md
# Segmented Capture Buffer Controller

This block records probed samples into an on-chip memory when trigger events arrive. Each memory entry holds two probe words side by side: a 12-bit sample word and an 8-bit tag word. At start time the memory is split into a power-of-two number of equal windows. Each window records one separate trigger occurrence. The trigger sample goes into the first slot of the window, and the samples that follow fill the remaining slots.

After each window fills, the block re-arms for the next trigger. Once the last window is full it raises `done`. It then streams the whole memory out in ascending address order through a valid/ready port, and labels each entry with its window index and its offset from that window's trigger. A new `start` pulse clears everything and begins a fresh capture. Trigger generation and the host link sit outside this block.

The read port follows valid/ready rules. An entry moves on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the presented entry and its labels stay unchanged. The capture side cannot be stalled, so `smp_valid` acts as a plain enable with no ready signal.

Top module: `seg_cap_buf`

## Requirements
- R1: After reset, `armed`, `done` and `rd_valid` are low, and the block ignores samples and triggers until a `start` pulse arrives.
- R2: One cycle after `start`, `armed` is high and `done` is low. `win_log2` is sampled at `start` and selects 2^`win_log2` windows. Values above log2(DEPTH) are clamped to log2(DEPTH).
- R3: A trigger is accepted only on an edge where `armed`, `trig` and `smp_valid` are all high. A trigger with `smp_valid` low is ignored. The accepted sample is stored at offset 0 of the current window.
- R4: While a window is filling, `armed` is low. One sample is stored per edge with `smp_valid` high, and `trig` has no effect.
- R5: Window depth is DEPTH >> clamped `win_log2`. When a window that is not the last one completes, `armed` is high on the next cycle.
- R6: When the last window completes, `done` rises on the next cycle and `armed` stays low. Samples and triggers that arrive later do not change the stored data.
- R7: While `done` is high, the read port presents all DEPTH entries exactly once in ascending address order. `rd_a` carries bits [19:8] of the entry and `rd_b` carries bits [7:0].
- R8: For the entry at address A, `rd_win` = A >> (log2(DEPTH) - clamped `win_log2`) and `rd_ofs` = A mod window depth. `rd_ofs` = 0 marks the trigger sample.
- R9: While `rd_valid` is high and `rd_ready` is low, all read outputs hold. After the last entry is accepted, `rd_valid` stays low.
- R10: `done` stays high until the next `start`. A `start` in any state clears `done`, `rd_valid` and both pointers, and re-arms the block.
- R11: `armed` and `done` are never high together, and `rd_valid` is high only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new capture; samples the window setting |
| win_log2 | input | LW | log2 of the window count |
| smp_valid | input | 1 | Sample enable; storage happens only when high |
| smp_a | input | A_W | Main probe word |
| smp_b | input | B_W | Secondary probe word |
| trig | input | 1 | Trigger event for the current sample |
| armed | output | 1 | Waiting for a trigger |
| done | output | 1 | All windows full; readout allowed |
| rd_valid | output | 1 | Read entry present |
| rd_ready | input | 1 | Host accepts the read entry |
| rd_a | output | A_W | Stored main word |
| rd_b | output | B_W | Stored secondary word |
| rd_win | output | AW | Window index of the entry |
| rd_ofs | output | AW | Offset of the entry from its window's trigger |

## Verification
Every cycle, the checker enforces the following. `armed` and `done` are never high together. Read data only appears after completion and holds under back-pressure. `done` persists until a restart, and `start` clears and re-arms the block. `done` rises only after a stored sample. The bench scenarios are needed for the rest, because they depend on the data path and on counting. They show that triggers are placed at offset 0 of each window and that window depths follow the clamped setting. They also show that stalled cycles and late triggers leave the memory untouched, and that every entry comes back in order with the correct window and offset labels.

// File: rtl/seg_cap_pkg.sv
package seg_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_win_seq.sv
module cap_win_seq
  import seg_cap_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] win_log2,
  input  logic          smp_valid,
  input  logic          trig,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          armed,
  output logic          done,
  output logic [LW-1:0] wl_q
);
  cap_state_e    st;
  logic [LW-1:0] wl_clamp;
  logic [AW-1:0] ofs_mask;
  logic          win_end;
  logic          last_slot;

  // Window setting is clamped once, at start.
  assign wl_clamp  = (win_log2 > LW'(AW)) ? LW'(AW) : win_log2;
  assign ofs_mask  = {AW{1'b1}} >> wl_q;
  assign win_end   = (wr_addr & ofs_mask) == ofs_mask;
  assign last_slot = &wr_addr;

  assign wr_en = smp_valid && (((st == ST_ARMED) && trig) || (st == ST_FILL));
  assign armed = (st == ST_ARMED);
  assign done  = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_addr <= '0;
      wl_q    <= '0;
    end else if (start) begin
      st      <= ST_ARMED;
      wr_addr <= '0;
      wl_q    <= wl_clamp;
    end else if (wr_en) begin
      wr_addr <= wr_addr + 1'b1;
      if (last_slot)    st <= ST_DONE;
      else if (win_end) st <= ST_ARMED;
      else              st <= ST_FILL;
    end
  end
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 20
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned N = 1 << AW;
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cap_rd_stream.sv
module cap_rd_stream #(
  parameter int unsigned AW = 10,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          done,
  input  logic [LW-1:0] wl_q,
  input  logic          rd_ready,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [AW-1:0] rd_win,
  output logic [AW-1:0] rd_ofs
);
  logic [AW:0]   ptr;
  logic          more;
  logic [LW-1:0] shr;
  logic [AW-1:0] ofs_mask;

  assign more     = ~ptr[AW];
  assign rd_addr  = ptr[AW-1:0];
  assign shr      = LW'(AW) - wl_q;
  assign ofs_mask = {AW{1'b1}} >> wl_q;
  // Load the output stage when it is empty or being drained.
  assign rd_en    = done && more && (!rd_valid || rd_ready);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      ptr      <= '0;
      rd_valid <= 1'b0;
      rd_win   <= '0;
      rd_ofs   <= '0;
    end else if (rd_en) begin
      ptr      <= ptr + 1'b1;
      rd_valid <= 1'b1;
      rd_win   <= rd_addr >> shr;
      rd_ofs   <= rd_addr & ofs_mask;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_cap_buf.sv
module seg_cap_buf #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned A_W   = 12,
  parameter int unsigned B_W   = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [LW-1:0]  win_log2,
  input  logic           smp_valid,
  input  logic [A_W-1:0] smp_a,
  input  logic [B_W-1:0] smp_b,
  input  logic           trig,
  output logic           armed,
  output logic           done,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [A_W-1:0] rd_a,
  output logic [B_W-1:0] rd_b,
  output logic [AW-1:0]  rd_win,
  output logic [AW-1:0]  rd_ofs
);
  localparam int unsigned DW = A_W + B_W;

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [LW-1:0] wl_q;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  cap_win_seq #(.AW(AW), .LW(LW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .win_log2(win_log2),
    .smp_valid(smp_valid), .trig(trig), .wr_en(wr_en), .wr_addr(wr_addr),
    .armed(armed), .done(done), .wl_q(wl_q)
  );

  cap_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data({smp_a, smp_b}),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cap_rd_stream #(.AW(AW), .LW(LW)) rd_i (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .wl_q(wl_q),
    .rd_ready(rd_ready), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_win(rd_win), .rd_ofs(rd_ofs)
  );

  assign rd_a = rd_data[DW-1:B_W];
  assign rd_b = rd_data[B_W-1:0];
endmodule

// File: rtl/seg_cap_buf_chk.sv
module seg_cap_buf_chk #(
  parameter int unsigned A_W = 12,
  parameter int unsigned B_W = 8,
  parameter int unsigned AW  = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           smp_valid,
  input logic           armed,
  input logic           done,
  input logic           rd_valid,
  input logic           rd_ready,
  input logic [A_W-1:0] rd_a,
  input logic [B_W-1:0] rd_b,
  input logic [AW-1:0]  rd_win,
  input logic [AW-1:0]  rd_ofs
);
  a_r11_armed_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && done));

  a_r11_rdv_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !start) |=>
      (rd_valid && $stable(rd_a) && $stable(rd_b) && $stable(rd_win) && $stable(rd_ofs)));

  a_r10_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (armed && !done && !rd_valid));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r6_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(smp_valid));
endmodule

bind seg_cap_buf seg_cap_buf_chk #(.A_W(A_W), .B_W(B_W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
  .armed(armed), .done(done), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_a(rd_a), .rd_b(rd_b), .rd_win(rd_win), .rd_ofs(rd_ofs)
);

// File: tb/seg_cap_buf_tb_top.sv
module seg_cap_buf_tb_top;
  localparam int CLK_P    = 10;
  localparam int DEPTH    = 64;
  localparam int AW       = 6;
  localparam int LW       = 3;
  localparam int WD_LIMIT = 100000;
  // Rows: {win_log2 input, pacing period}. Row 3 uses 7, which clamps to 6.
  localparam int NV = 4;
  localparam int VEC [NV][2] = '{'{3, 1}, '{0, 2}, '{6, 1}, '{7, 3}};

  logic clk = 1'b0;
  logic rst_n, start, smp_valid, trig, rd_ready;
  logic [LW-1:0] win_log2;
  logic [11:0] smp_a, rd_a;
  logic [7:0]  smp_b, rd_b;
  logic armed, done, rd_valid;
  logic [AW-1:0] rd_win, rd_ofs;

  seg_cap_buf #(.DEPTH(DEPTH), .A_W(12), .B_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .win_log2(win_log2),
    .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b), .trig(trig),
    .armed(armed), .done(done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_a(rd_a), .rd_b(rd_b), .rd_win(rd_win), .rd_ofs(rd_ofs)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int s      = 0;
  logic [11:0] exp_a [DEPTH];
  logic [7:0]  exp_b [DEPTH];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  // Drive one cycle of capture inputs; addr >= 0 records the expected entry.
  task automatic put(input bit v, input bit t, input int addr);
    smp_valid = v;
    trig      = t;
    smp_a     = 12'(s * 5 + 3);
    smp_b     = ~8'(s);
    if (addr >= 0) begin
      exp_a[addr] = smp_a;
      exp_b[addr] = smp_b;
    end
    s++;
    @(negedge clk);
  endtask

  task automatic pulse_start(input int wl);
    win_log2 = LW'(wl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_capture(input int wl, input int per);
    int ewl, wd, nw, base;
    ewl = (wl > AW) ? AW : wl;
    wd  = DEPTH >> ewl;
    nw  = 1 << ewl;
    pulse_start(wl);
    chk(armed && !done, "R2", "armed after start", int'(armed), 1);
    for (int w = 0; w < nw; w++) begin
      base = w * wd;
      put(1'b0, 1'b1, -1);
      chk(armed == 1'b1, "R3", "trigger without valid ignored", int'(armed), 1);
      put(1'b1, 1'b1, base);
      chk(armed == ((wd == 1) && (w < nw - 1)), "R4", "armed after trigger",
          int'(armed), int'((wd == 1) && (w < nw - 1)));
      for (int i = 1; i < wd; i++) begin
        for (int k = 1; k < per; k++) put(1'b0, 1'(i % 2), -1);
        put(1'b1, 1'(i % 2), base + i);
      end
      if (wd > 1)
        chk(armed == (w < nw - 1), "R5", "re-arm after window", int'(armed),
            int'(w < nw - 1));
      chk(done == (w == nw - 1), "R6", "done after last window", int'(done),
          int'(w == nw - 1));
    end
    for (int k = 0; k < 3; k++) begin
      put(1'b1, 1'b1, -1);
      chk(done && !armed, "R6", "late samples ignored, state", int'(armed), 0);
    end
    put(1'b0, 1'b0, -1);
  endtask

  task automatic readback(input int wl, input int per);
    int ewl, wd, idx, guard;
    bit rr, held;
    logic [11:0] ha;
    logic [AW-1:0] hw;
    ewl = (wl > AW) ? AW : wl;
    wd  = DEPTH >> ewl;
    idx = 0; guard = 0; held = 1'b0; ha = '0; hw = '0;
    while (idx < DEPTH && guard < 5000) begin
      rr = ((guard % per) == 0);
      rd_ready = rr;
      #1;
      if (held) begin
        chk(rd_valid && rd_a == ha && rd_win == hw, "R9", "hold under stall",
            int'(rd_a), int'(ha));
      end
      held = 1'b0;
      if (rd_valid && rr) begin
        chk(rd_a == exp_a[idx] && rd_b == exp_b[idx], "R7", "entry data",
            int'({rd_a, rd_b}), int'({exp_a[idx], exp_b[idx]}));
        chk(int'(rd_win) == (idx >> (AW - ewl)) && int'(rd_ofs) == (idx % wd),
            "R8", "window/offset label", int'({rd_win, rd_ofs}),
            ((idx >> (AW - ewl)) << AW) | (idx % wd));
        idx++;
      end else if (rd_valid) begin
        held = 1'b1; ha = rd_a; hw = rd_win;
      end
      @(negedge clk);
      guard++;
    end
    chk(idx == DEPTH, "R7", "entries delivered", idx, DEPTH);
    rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rd_valid, "R9", "no entry after last", int'(rd_valid), 0);
    chk(done == 1'b1, "R10", "done persists through readout", int'(done), 1);
    rd_ready = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; smp_valid = 1'b0; trig = 1'b0;
    rd_ready = 1'b0; win_log2 = '0; smp_a = '0; smp_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!armed && !done && !rd_valid, "R1", "reset state",
        int'({armed, done, rd_valid}), 0);
    put(1'b1, 1'b1, -1);
    put(1'b1, 1'b1, -1);
    chk(!armed && !done, "R1", "idle ignores triggers", int'({armed, done}), 0);

    for (int v = 0; v < NV; v++) begin
      run_capture(VEC[v][0], VEC[v][1]);
      readback(VEC[v][0], VEC[v][1]);
    end

    // R10: restart in the middle of a window fill.
    pulse_start(2);
    put(1'b1, 1'b1, -1);
    put(1'b1, 1'b0, -1);
    put(1'b1, 1'b0, -1);
    chk(!armed, "R4", "filling before restart", int'(armed), 0);
    pulse_start(1);
    chk(armed && !done, "R10", "restart mid-fill re-arms", int'(armed), 1);
    run_capture(1, 1);
    readback(1, 2);

    // R10: restart in the middle of readout.
    run_capture(4, 1);
    rd_ready = 1'b1;
    repeat (5) @(negedge clk);
    rd_ready = 1'b0;
    pulse_start(4);
    chk(!done && !rd_valid && armed, "R10", "restart during readout",
        int'({armed, done, rd_valid}), 4);
    run_capture(4, 2);
    readback(4, 1);

    summary();
    $finish;
  end
endmodule